// File: doc/BRIEF.md
# Reset Control Port

This block is a single-byte register on a simple byte-wide I/O bus through which software asks the system for a reset. It answers at exactly one I/O address, set by a parameter. Accesses to any other address are ignored.

A write whose trigger bit is set does not change the register. Instead, the block emits a reset-request pulse one clock wide on the next cycle. This pulse goes to an external reset sequencer. A write with the trigger bit clear keeps only the reset-type bit and clears every other bit. A read returns the stored byte one cycle after the read strobe, qualified by a one-cycle valid flag. The stored byte is zero after hardware reset.

Top module: `rst_ctrl_port`

## Requirements
- R1: While and after `rst_n` is low, the stored byte is 0x00 and `sys_rst_req` and `io_rvalid` are low.
- R2: A write to the port address with data bit 2 set drives `sys_rst_req` high for exactly one clock, in the cycle after the write strobe.
- R3: A write to the port address with data bit 2 set leaves the stored byte unchanged.
- R4: A write to the port address with data bit 2 clear stores data bit 1 in bit 1 and zero in all other bits. It does not raise `sys_rst_req`.
- R5: A read strobe at the port address drives `io_rvalid` high for one clock in the next cycle, with `io_rdata` equal to the stored byte. `io_rdata` is 0x00 whenever `io_rvalid` is low.
- R6: Reads and writes at any other address (default port 0xCF9) change nothing: no store, no `sys_rst_req`, no `io_rvalid`.
- R7: A read and a write to the port in the same cycle return the byte held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 16 | I/O address of the access |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wdata | input | 8 | Write data byte |
| io_rdata | output | 8 | Read data byte, valid with `io_rvalid` |
| io_rvalid | output | 1 | Read data valid, one cycle |
| sys_rst_req | output | 1 | Reset request pulse to the sequencer |

## Verification
Every result of this block is due exactly one clock after the strobe that caused it. This holds for the read data and valid flag and for the reset request. A register update becomes visible to a read issued on the following cycle.

The bench drives each access on a falling edge and samples the outputs on the next falling edge, which is one rising edge later. It samples once more a cycle after that, to show that the pulse and the valid flag have dropped again. The stored value is always checked through an ordinary read at the port, never by looking inside the design.

// File: rtl/rst_ctrl_pkg.sv
package rst_ctrl_pkg;
   // one-hot byte helper used for bit masks
   function automatic logic [7:0] bit_mask8(input int unsigned pos);
      logic [7:0] m;
      m = '0;
      m[pos[2:0]] = 1'b1;
      return m;
   endfunction
endpackage

// File: rtl/rst_ctrl_decode.sv
module rst_ctrl_decode #(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned DATA_W    = 8,
   parameter logic [ADDR_W-1:0] PORT_ADDR = 16'hCF9,
   parameter int unsigned TRIG_BIT  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_wr,
   input  logic              io_rd,
   input  logic [DATA_W-1:0] io_wdata,
   output logic              fire,
   output logic              store_en,
   output logic              rd_hit
);
   logic sel;

   if (TRIG_BIT >= DATA_W) begin : g_bad_trig
      $error("TRIG_BIT outside data width");
   end

   assign sel      = (io_addr == PORT_ADDR);
   assign fire     = sel & io_wr &  io_wdata[TRIG_BIT];
   assign store_en = sel & io_wr & ~io_wdata[TRIG_BIT];
   assign rd_hit   = sel & io_rd;

   // a trigger write and a storing write never coincide
   assert_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(fire && store_en));
endmodule

// File: rtl/rst_ctrl_store.sv
module rst_ctrl_store #(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned TYPE_BIT = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              store_en,
   input  logic              rd_hit,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] stored,
   output logic [DATA_W-1:0] rdata,
   output logic              rvalid
);
   logic [DATA_W-1:0] keep;

   if (TYPE_BIT >= DATA_W) begin : g_bad_type
      $error("TYPE_BIT outside data width");
   end

   for (genvar b = 0; b < DATA_W; b++) begin : g_keep
      assign keep[b] = (b == TYPE_BIT);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stored <= '0;
         rdata  <= '0;
         rvalid <= 1'b0;
      end else begin
         if (store_en) stored <= wdata & keep;
         rvalid <= rd_hit;
         rdata  <= rd_hit ? stored : '0;
      end
   end

   assert_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
      store_en |=> (stored[TYPE_BIT] == $past(wdata[TYPE_BIT])) &&
                   ($countones(stored) <= 1));
   assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !store_en |=> $stable(stored));
   assert_rvalid_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rvalid |-> $past(rd_hit));
   assert_rzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !rvalid |-> (rdata == '0));
endmodule

// File: rtl/rst_ctrl_pulse.sv
module rst_ctrl_pulse (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   output logic req
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req <= 1'b0;
      else        req <= fire;
   end

   assert_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      req |-> $past(fire));
   assert_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> req);
endmodule

// File: rtl/rst_ctrl_port.sv
module rst_ctrl_port #(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned DATA_W    = 8,
   parameter logic [ADDR_W-1:0] PORT_ADDR = 16'hCF9,
   parameter int unsigned TRIG_BIT  = 2,
   parameter int unsigned TYPE_BIT  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_wr,
   input  logic              io_rd,
   input  logic [DATA_W-1:0] io_wdata,
   output logic [DATA_W-1:0] io_rdata,
   output logic              io_rvalid,
   output logic              sys_rst_req
);
   logic fire, store_en, rd_hit;
   logic [DATA_W-1:0] stored;

   if (TRIG_BIT == TYPE_BIT) begin : g_bad_bits
      $error("trigger and type bits must differ");
   end

   rst_ctrl_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W),
                     .PORT_ADDR(PORT_ADDR), .TRIG_BIT(TRIG_BIT)) u_dec (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
      .io_rd(io_rd), .io_wdata(io_wdata), .fire(fire),
      .store_en(store_en), .rd_hit(rd_hit));

   rst_ctrl_store #(.DATA_W(DATA_W), .TYPE_BIT(TYPE_BIT)) u_store (
      .clk(clk), .rst_n(rst_n), .store_en(store_en), .rd_hit(rd_hit),
      .wdata(io_wdata), .stored(stored), .rdata(io_rdata),
      .rvalid(io_rvalid));

   rst_ctrl_pulse u_pulse (
      .clk(clk), .rst_n(rst_n), .fire(fire), .req(sys_rst_req));

   assert_other_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (io_addr != PORT_ADDR) |=> !sys_rst_req && !io_rvalid && $stable(stored));
   assert_reset_R1: assert property (@(posedge clk)
      !rst_n |-> (stored == '0) && !sys_rst_req && !io_rvalid);
endmodule

// File: tb/rst_ctrl_port_tb.sv
module rst_ctrl_port_tb;
   localparam logic [15:0] PORT = 16'hCF9;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [15:0] io_addr = '0;
   logic io_wr = 1'b0, io_rd = 1'b0;
   logic [7:0] io_wdata = '0;
   logic [7:0] io_rdata;
   logic io_rvalid, sys_rst_req;

   int total = 0, bad = 0;
   bit done = 0;
   logic [7:0] model = '0;

   always #5 clk = ~clk;

   rst_ctrl_port u_dut (.clk(clk), .rst_n(rst_n), .io_addr(io_addr),
      .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata),
      .io_rdata(io_rdata), .io_rvalid(io_rvalid), .sys_rst_req(sys_rst_req));

   function automatic logic [7:0] next_val(logic [7:0] cur, logic [7:0] d);
      return d[2] ? cur : (d & 8'h02);
   endfunction

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // one access: strobes for one cycle, results one cycle later, then idle
   task automatic access(input logic [15:0] a, input bit wr, input bit rd,
                         input logic [7:0] d);
      bit hit;
      logic [7:0] exp_rd;
      hit = (a == PORT);
      exp_rd = model;                       // R7: read sees pre-write value
      @(negedge clk);
      io_addr = a; io_wr = wr; io_rd = rd; io_wdata = d;
      @(negedge clk);
      io_wr = 0; io_rd = 0;
      check(sys_rst_req == (hit && wr && d[2]), "R2/R4/R6 req", sys_rst_req, hit && wr && d[2]);
      check(io_rvalid == (hit && rd), "R5/R6 rvalid", io_rvalid, hit && rd);
      check(io_rdata == ((hit && rd) ? exp_rd : 8'h00), "R5/R7 rdata", io_rdata,
            (hit && rd) ? exp_rd : 8'h00);
      if (hit && wr) model = next_val(model, d); // R3 R4
      @(negedge clk);
      check(!sys_rst_req, "R2 pulse width", sys_rst_req, 0);
      check(!io_rvalid, "R5 valid width", io_rvalid, 0);
   endtask

   initial begin
      int seed;
      seed = 32'h5eed;
      void'($urandom(seed));
      repeat (3) @(negedge clk);
      check(!sys_rst_req && !io_rvalid && io_rdata == 0, "R1 reset outputs", sys_rst_req, 0);
      rst_n = 1'b1;
      access(PORT, 0, 1, 8'h00);            // R1 stored zero
      access(PORT, 1, 0, 8'hFF & ~8'h04);   // R4 only bit1 kept
      access(PORT, 0, 1, 8'h00);
      access(PORT, 1, 0, 8'hFF);            // R3 trigger keeps value
      access(PORT, 0, 1, 8'h00);
      access(16'hCF8, 1, 0, 8'h00);         // R6 other address ignored
      access(16'h0CF9 ^ 16'h1000, 0, 1, 8'h00);
      access(PORT, 0, 1, 8'h00);
      access(PORT, 1, 1, 8'h00);            // R7 same-cycle read/write
      access(PORT, 0, 1, 8'h00);
      for (int i = 0; i < 400; i++) begin
         logic [15:0] a;
         int k;
         k = $urandom_range(0, 3);
         a = (k == 0) ? 16'($urandom) : PORT;
         access(a, $urandom_range(0, 1), $urandom_range(0, 1), 8'($urandom));
      end
      // reset mid-run clears the register
      access(PORT, 1, 0, 8'h02);
      @(negedge clk); rst_n = 0; model = 0;
      @(negedge clk);
      check(!sys_rst_req && !io_rvalid, "R1 reset again", io_rvalid, 0);
      rst_n = 1;
      access(PORT, 0, 1, 8'h00);
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule